// File: doc/BRIEF.md
# Serial Register Port with Burst Access

This block is a slave port for a host serial link framed by an active-low chip select. It gives the host access to a bank of eleven byte-wide registers. The register bank itself sits outside the block, behind a simple side bus with an address, write data, a write strobe, combinational read data and a read strobe. The register bank uses the read strobe to clear its status registers after the host has seen them.

Every transfer opens with a command byte. Its bit 0 selects the operation: 0 writes and 1 reads. Bits 4..1 carry the register address, with bit 1 as the address LSB. Bits 6..5 are reserved and must be zero. Bit 7 asks for burst mode. One data byte follows the command, or, in burst mode, every register in turn starting at address 0. All bytes move least significant bit first. The host clock is sampled inside the block on the system clock. Incoming data is taken on serial clock rising edges, and outgoing data changes on falling edges.

Top module: `serial_reg_port`

## Requirements
- R1: The command byte is received LSB first. Bit 0 = 1 selects a read and bit 0 = 0 selects a write. Bits 4..1 form the register address, with bit 1 as its LSB.
- R2: A write produces exactly one single-cycle `regWr` pulse, and only once all eight data bits have arrived on rising serial clock edges. The pulse carries the byte assembled LSB first. A data byte cut short by chip select produces no write.
- R3: For a read, bit 0 of the addressed register appears on `sdo` at the first falling serial clock edge after the eighth command bit. The remaining bits follow on the next falling edges, and each bit is held until the next falling edge.
- R4: A single-register read pulses `regRd` exactly once, for one cycle. A burst read never pulses `regRd`, so the status registers at addresses 5 and 7 keep their contents. `regWr` and `regRd` are never high together.
- R5: Bit 7 = 1 together with address 0 starts a burst. Successive bytes go to or come from addresses 0, 1, 2 and so on up to 10. Bytes after the one for address 10 are ignored.
- R6: Bit 7 = 1 with a non-zero address gives an ordinary one-byte transfer. Further bytes are ignored.
- R7: A command with either bit 6 or bit 5 set is ignored: no `regWr`, no `regRd`, and `sdo` stays undriven until chip select rises.
- R8: Addresses 11 to 15 read as 0x00, and writes to them produce no `regWr`. Neither strobe is ever raised with an address above 10.
- R9: `sdoOe` is low while chip select is high and throughout every write transfer.
- R10: Raising chip select aborts any transfer. The next transfer after it starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Host serial clock |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdoOe | output | 1 | Output enable for `sdo`; low means tri-stated |
| regAddr | output | 4 | Register-bank address |
| regWrData | output | 8 | Register-bank write data |
| regWr | output | 1 | One-cycle write strobe |
| regRdData | input | 8 | Register-bank read data, combinational from `regAddr` |
| regRd | output | 1 | One-cycle read strobe for single reads; used to clear status |

## Verification
Host inputs pass through a two-stage synchronizer and an edge register. As a result, `regWr` is high in the third system clock cycle after a rising serial clock edge, and `sdo` settles three cycles after a falling edge. The bench holds each serial clock phase for eight system clocks and reads `sdo` just before the next rising edge, once the last falling edge has long settled. Strobe pulses are counted continuously by the bench, and those counts are compared only after chip select has been high for several cycles.

// File: rtl/sport_pkg.sv
package sport_pkg;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_DATA,
    PH_HALT
  } phase_t;

  // strobes from control to datapath, one system clock wide
  typedef struct packed {
    logic clear;     // chip select is high
    logic shiftIn;   // take one sdi bit
    logic latchCmd;  // command byte accepted, capture address
    logic commitWr;  // a full write byte is complete
    logic nextAddr;  // burst: step to next address
    logic fetch;     // load transmit byte from the register bank
    logic fetchClr;  // fetch may signal clear-on-read
    logic shiftOut;  // falling edge in a read: drive next bit
  } strobe_t;

endpackage

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import sport_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [DATA_W-1:0] rxNext,
  input  logic              addrLast,
  output logic              sdiS,
  output strobe_t           strb
);

  localparam int CNT_W     = $clog2(DATA_W);
  localparam int RW_BIT    = 0;
  localparam int ADDR_LSB  = 1;
  localparam int RSV_LSB   = ADDR_LSB + ADDR_W;
  localparam int BURST_BIT = DATA_W - 1;
  localparam int RSV_W     = BURST_BIT - RSV_LSB;

  logic [SYNC_STAGES-1:0] csSync, sclkSync, sdiSync;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        csSync[g]   <= 1'b1;
        sclkSync[g] <= 1'b0;
        sdiSync[g]  <= 1'b0;
      end else if (g == 0) begin
        csSync[g]   <= csN;
        sclkSync[g] <= sclk;
        sdiSync[g]  <= sdi;
      end else begin
        csSync[g]   <= csSync[g-1];
        sclkSync[g] <= sclkSync[g-1];
        sdiSync[g]  <= sdiSync[g-1];
      end
    end
  end

  logic csS, sclkS, sclkPrev;
  assign csS   = csSync[SYNC_STAGES-1];
  assign sclkS = sclkSync[SYNC_STAGES-1];
  assign sdiS  = sdiSync[SYNC_STAGES-1];

  phase_t     phase;
  logic [CNT_W-1:0] bitCnt;
  logic       isRead, isBurst, fetchPend;
  logic       rise, fall, byteEnd, cmdOk, advance, cmdBurst;

  assign rise     = sclkS & ~sclkPrev & ~csS;
  assign fall     = ~sclkS & sclkPrev & ~csS;
  assign byteEnd  = rise && (bitCnt == CNT_W'(DATA_W - 1));
  assign cmdOk    = (rxNext[RSV_LSB +: RSV_W] == '0);
  assign cmdBurst = rxNext[BURST_BIT] && (rxNext[ADDR_LSB +: ADDR_W] == '0);
  assign advance  = (phase == PH_DATA) && byteEnd && isBurst && !addrLast;

  always_comb begin
    strb          = '0;
    strb.clear    = csS;
    strb.shiftIn  = rise;
    strb.latchCmd = (phase == PH_CMD) && byteEnd && cmdOk;
    strb.commitWr = (phase == PH_DATA) && byteEnd && !isRead;
    strb.nextAddr = advance;
    strb.fetch    = fetchPend;
    strb.fetchClr = !isBurst;
    strb.shiftOut = fall && isRead && (phase != PH_CMD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      phase     <= PH_CMD;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      isBurst   <= 1'b0;
      fetchPend <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      if (csS) begin
        phase     <= PH_CMD;
        bitCnt    <= '0;
        isRead    <= 1'b0;
        isBurst   <= 1'b0;
        fetchPend <= 1'b0;
      end else begin
        if (rise) bitCnt <= bitCnt + 1'b1;
        fetchPend <= (strb.latchCmd && rxNext[RW_BIT]) || (advance && isRead);
        if (byteEnd) begin
          unique case (phase)
            PH_CMD: begin
              if (cmdOk) begin
                phase   <= PH_DATA;
                isRead  <= rxNext[RW_BIT];
                isBurst <= cmdBurst;
              end else begin
                phase <= PH_HALT;
              end
            end
            PH_DATA: if (!advance) phase <= PH_HALT;
            default: phase <= PH_HALT;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/sport_dp.sv
module sport_dp
  import sport_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdiS,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] rxNext,
  output logic              addrLast,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWr,
  output logic              regRd,
  output logic              sdo,
  output logic              sdoOe
);

  localparam int ADDR_LSB = 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  logic [DATA_W-1:0] rxShift, txReg;
  logic [ADDR_W-1:0] addrReg;
  logic              inRange;

  assign rxNext    = {sdiS, rxShift[DATA_W-1:1]};
  assign inRange   = (addrReg <= LAST_ADDR);
  assign addrLast  = (addrReg == LAST_ADDR);
  assign regAddr   = addrReg;
  assign regWrData = rxNext;
  assign regWr     = strb.commitWr & inRange;
  assign regRd     = strb.fetch & strb.fetchClr & inRange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txReg   <= '0;
      addrReg <= '0;
      sdo     <= 1'b0;
      sdoOe   <= 1'b0;
    end else if (strb.clear) begin
      rxShift <= '0;
      txReg   <= '0;
      sdoOe   <= 1'b0;
    end else begin
      if (strb.shiftIn)  rxShift <= rxNext;
      if (strb.latchCmd) addrReg <= rxNext[ADDR_LSB +: ADDR_W];
      else if (strb.nextAddr) addrReg <= addrReg + 1'b1;
      if (strb.fetch) txReg <= inRange ? regRdData : '0;
      else if (strb.shiftOut) txReg <= {1'b0, txReg[DATA_W-1:1]};
      if (strb.shiftOut) begin
        sdo   <= txReg[0];
        sdoOe <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import sport_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int NUM_REGS    = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWr,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regRd
);

  strobe_t           strb;
  logic              sdiS, addrLast;
  logic [DATA_W-1:0] rxNext;

  sport_ctrl #(.SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .rxNext(rxNext), .addrLast(addrLast), .sdiS(sdiS), .strb(strb)
  );

  sport_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .sdiS(sdiS), .strb(strb), .regRdData(regRdData),
    .rxNext(rxNext), .addrLast(addrLast), .regAddr(regAddr),
    .regWrData(regWrData), .regWr(regWr), .regRd(regRd),
    .sdo(sdo), .sdoOe(sdoOe)
  );

endmodule

// File: rtl/serial_reg_port_chk.sv
module serial_reg_port_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4,
  parameter int NUM_REGS    = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              sdoOe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWr,
  input logic              regRd
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  logic [3:0] csHiCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          csHiCnt <= '0;
    else if (csN)       csHiCnt <= (csHiCnt == 4'hF) ? csHiCnt : csHiCnt + 1'b1;
    else                csHiCnt <= '0;
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(regWr && regRd));
  // R8
  wr_range_chk: assert property (@(posedge clk) disable iff (!rstN) regWr |-> regAddr <= LAST_ADDR);
  // R8
  rd_range_chk: assert property (@(posedge clk) disable iff (!rstN) regRd |-> regAddr <= LAST_ADDR);
  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) regWr |=> !regWr);
  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) regRd |=> !regRd);
  // R9
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (32'(csHiCnt) > SYNC_STAGES + 1) |-> !sdoOe);

endmodule

bind serial_reg_port serial_reg_port_chk #(
  .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sdoOe(sdoOe),
  .regAddr(regAddr), .regWr(regWr), .regRd(regRd)
);

// File: tb/serial_reg_port_tb.sv
module serial_reg_port_tb;

  localparam int H = 8;  // system clocks per serial clock phase
  localparam int NREG = 11;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdoOe, regWr, regRd;
  logic [3:0] regAddr;
  logic [7:0] regWrData, regRdData;

  always #2.5 clk = ~clk;

  serial_reg_port u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe), .regAddr(regAddr), .regWrData(regWrData),
    .regWr(regWr), .regRdData(regRdData), .regRd(regRd)
  );

  // register bank model: status at 5 and 7 clears on regRd
  logic [7:0] bank [0:NREG-1];
  int wrCnt = 0, rdCnt = 0;
  assign regRdData = (int'(regAddr) < NREG) ? bank[int'(regAddr)] : 8'hA5;

  always_ff @(posedge clk) begin
    if (regWr) begin
      wrCnt <= wrCnt + 1;
      if (int'(regAddr) < NREG) bank[int'(regAddr)] <= regWrData;
    end
    if (regRd) begin
      rdCnt <= rdCnt + 1;
      if (regAddr == 4'd5 || regAddr == 4'd7) bank[int'(regAddr)] <= 8'h00;
    end
  end

  int nChk = 0, nFail = 0;
  bit done = 1'b0;
  logic [7:0] expv [0:NREG-1];
  logic [7:0] txb [0:15];
  logic [7:0] rxb [0:15];
  bit oeSeen;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic [7:0] r, input int nBits);
    r = '0;
    for (int i = 0; i < nBits; i++) begin
      sdi = b[i];
      r[i] = sdo;
      oeSeen |= sdoOe;
      waitClk(H);
      sclk = 1'b1;
      waitClk(H);
      sclk = 1'b0;
      waitClk(H);
      oeSeen |= sdoOe;
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input int nb, input int cutBits);
    logic [7:0] dummy;
    oeSeen = 1'b0;
    csN = 1'b0;
    waitClk(H);
    sendByte(cmd, dummy, 8);
    for (int k = 0; k < nb; k++) sendByte(txb[k], rxb[k], 8);
    if (cutBits > 0) sendByte(txb[nb], dummy, cutBits);
    waitClk(H);
    csN = 1'b1;
    waitClk(3 * H);
  endtask

  function automatic logic [7:0] cmdOf(input int addr, input bit rd, input bit burst);
    return {burst, 2'b00, 4'(addr), rd};
  endfunction

  function automatic logic [7:0] expRead(input int addr);
    return (addr < NREG) ? expv[addr] : 8'h00;
  endfunction

  task automatic wr1(input int addr, input logic [7:0] v);
    txb[0] = v;
    xfer(cmdOf(addr, 1'b0, 1'b0), 1, 0);
    if (addr < NREG) expv[addr] = v;
  endtask

  task automatic rd1(input int addr, input string req);
    logic [7:0] e;
    e = expRead(addr);
    xfer(cmdOf(addr, 1'b1, 1'b0), 1, 0);
    chk(rxb[0] == e, req, rxb[0], e);
    if (addr == 5 || addr == 7) expv[addr] = 8'h00;
  endtask

  initial begin
    int w0, r0;
    for (int i = 0; i < NREG; i++) begin
      bank[i] = 8'h00;
      expv[i] = 8'h00;
    end
    void'($urandom(32'd20240611));
    waitClk(4);
    // reset state
    chk(sdoOe == 1'b0, "R9 reset oe", sdoOe, 0);
    chk(regWr == 1'b0, "R2 reset regWr", regWr, 0);
    chk(regRd == 1'b0, "R4 reset regRd", regRd, 0);
    rstN = 1'b1;
    waitClk(4);

    // R1 R2 R3: single write then read
    w0 = wrCnt;
    wr1(2, 8'h3C);
    chk(wrCnt - w0 == 1, "R2 one write pulse", wrCnt - w0, 1);
    chk(oeSeen == 1'b0, "R9 oe during write", oeSeen, 0);
    rd1(2, "R1 R3 readback");
    chk(oeSeen == 1'b1, "R3 oe during read", oeSeen, 1);

    // R4: single read of a status register clears it
    wr1(5, 8'h81);
    r0 = rdCnt;
    rd1(5, "R4 status read");
    chk(rdCnt - r0 == 1, "R4 one read pulse", rdCnt - r0, 1);
    rd1(5, "R4 status cleared");

    // R5: burst write with one extra byte
    for (int k = 0; k < 12; k++) txb[k] = 8'(k * 17 + 3);
    w0 = wrCnt;
    xfer(cmdOf(0, 1'b0, 1'b1), 12, 0);
    for (int k = 0; k < NREG; k++) expv[k] = txb[k];
    chk(wrCnt - w0 == NREG, "R5 burst write count", wrCnt - w0, NREG);
    // R5 R4: burst read, no read strobes
    r0 = rdCnt;
    xfer(cmdOf(0, 1'b1, 1'b1), 11, 0);
    for (int k = 0; k < NREG; k++)
      chk(rxb[k] == expv[k], "R5 burst read data", rxb[k], expv[k]);
    chk(rdCnt == r0, "R4 burst read no strobe", rdCnt - r0, 0);
    rd1(7, "R4 status kept after burst");

    // R6: burst bit with non-zero address
    w0 = wrCnt;
    txb[0] = 8'hC4; txb[1] = 8'h5B;
    xfer(cmdOf(3, 1'b0, 1'b1), 2, 0);
    expv[3] = 8'hC4;
    chk(wrCnt - w0 == 1, "R6 single write only", wrCnt - w0, 1);
    rd1(3, "R6 addr3");
    rd1(4, "R6 addr4 untouched");

    // R7: reserved bits set
    r0 = rdCnt;
    xfer(8'h20 | cmdOf(1, 1'b1, 1'b0), 1, 0);
    chk(oeSeen == 1'b0, "R7 no output", oeSeen, 0);
    chk(rdCnt == r0, "R7 no read strobe", rdCnt - r0, 0);
    w0 = wrCnt;
    txb[0] = 8'hEE;
    xfer(8'h40 | cmdOf(2, 1'b0, 1'b0), 1, 0);
    chk(wrCnt == w0, "R7 no write strobe", wrCnt - w0, 0);
    rd1(2, "R7 addr2 kept");

    // R8: out-of-range address
    w0 = wrCnt;
    wr1(12, 8'h77);
    chk(wrCnt == w0, "R8 no write", wrCnt - w0, 0);
    rd1(12, "R8 reads zero");
    rd1(15, "R8 reads zero top");

    // R2 R10: partial byte aborted
    w0 = wrCnt;
    txb[0] = 8'h99;
    xfer(cmdOf(2, 1'b0, 1'b0), 0, 5);
    chk(wrCnt == w0, "R2 partial discarded", wrCnt - w0, 0);
    rd1(2, "R10 fresh transfer after abort");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int a;
      a = int'($urandom % 16);
      if ($urandom % 2 == 0) wr1(a, 8'($urandom));
      else rd1(a, "R1 R3 R8 random read");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule